// File: doc/BRIEF.md
# Programmable Test Pulse Rate Generator

This block issues a periodic strobe, one clock cycle wide, meant to fire an external preamplifier test pulser. A 16-bit control word carries an enable bit and a 3-bit rate code. Codes 0 through 6 run an internal timer whose repetition rate starts at 100 Hz and doubles with each step, up to 6400 Hz. Code 7 turns the internal timer off. In that mode the strobe follows the rising edges of an external SYNC input.

The timer period in clock cycles is derived from the `CLK_HZ` and `BASE_HZ` parameters. The slowest code counts `CLK_HZ/BASE_HZ` cycles. Each higher code halves that count. A rate change written in the middle of an interval does not cut it short: the new rate is adopted only when the running interval ends. The strobe can also be steered onto a logic inspection output, as can the registered SYNC level.

Top module: `tpg_pulse_gen`

## Requirements
- R1: When control bit 11 (enable) is 0, `pulse_o` stays low, including on SYNC edges. Clearing enable in the middle of an interval discards it, and re-enabling starts a full new interval.
- R2: The rate code is read from control bits 14:12. Bits 10:0 and bit 15 have no effect on the output.
- R3: For codes 0 to 6, the period is P = (CLK_HZ/BASE_HZ) >> code cycles. The first pulse appears on the P-th rising edge that samples enable high, counting that first edge as 1, and later pulses follow every P cycles.
- R4: With code 7 and enable set, each rising edge of `sync_i` yields one pulse, on the first clock edge that samples `sync_i` high, and the internal timer yields none. In codes 0 to 6, `sync_i` has no effect on `pulse_o`.
- R5: A new rate code applied while the timer is running takes effect only at the next period boundary. The interval in progress completes with the old period, and the following interval uses the new one.
- R6: Each pulse lasts exactly one clock cycle. A SYNC level held high for many cycles yields a single pulse.
- R7: `insp_sel_i` steers the inspection output: value 0 gives the registered SYNC level (one cycle behind `sync_i`), value 1 gives `pulse_o`, and values 2 and 3 give a constant low.
- R8: While `rst_i` is high, the period counter is cleared and `pulse_o` and `insp_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 16 | Control word: bit 11 enable, bits 14:12 rate code |
| sync_i | input | 1 | External SYNC level, synchronous to clk_i |
| insp_sel_i | input | 2 | Inspection output source select |
| pulse_o | output | 1 | One-cycle test pulse strobe |
| insp_o | output | 1 | Logic inspection output |

## Verification
The bench predicts the clock cycle of every pulse and targets the following corner cases:
- **Rate code changed mid-interval, in both directions.** A design that applies the change at once would emit a runt or stretched interval.
- **Enable cleared and then restored.** A counter that keeps its residue would deliver a short first interval.
- **SYNC held high for several cycles.** A level-sensitive design would emit a train of pulses instead of one.
- **SYNC edges that should be ignored**, either while disabled or in timer mode. A design that leaks them would show pulses the scoreboard never queued.
- **The fastest code, with a four-cycle period.** An off-by-one in the halved terminal count would shift every pulse.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // Field positions inside the pulser control word.
    localparam int CFG_EN_BIT   = 11;
    localparam int CFG_RATE_LSB = 12;
    localparam int CFG_RATE_W   = 3;
    localparam int NUM_CODES    = 1 << CFG_RATE_W;

    typedef enum logic [CFG_RATE_W-1:0] {
        RATE_100HZ  = 3'd0,
        RATE_200HZ  = 3'd1,
        RATE_400HZ  = 3'd2,
        RATE_800HZ  = 3'd3,
        RATE_1600HZ = 3'd4,
        RATE_3200HZ = 3'd5,
        RATE_6400HZ = 3'd6,
        RATE_SYNC   = 3'd7
    } rate_e;

    typedef enum logic [1:0] {
        INSP_SYNC  = 2'd0,
        INSP_PULSE = 2'd1,
        INSP_OFF2  = 2'd2,
        INSP_OFF3  = 2'd3
    } insp_sel_e;

    typedef struct packed {
        logic  enable;
        rate_e rate;
    } tpg_cfg_t;

    // Period in cycles for a timed code: base period halved per step.
    function automatic int unsigned period_of(int unsigned base, int unsigned code);
        return base >> code;
    endfunction

    function automatic logic is_timed(rate_e r);
        return r != RATE_SYNC;
    endfunction

endpackage

// File: rtl/tpg_cfg_decode.sv
module tpg_cfg_decode
    import tpg_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output tpg_cfg_t          cfg_o
);

    localparam int RATE_MSB = CFG_RATE_LSB + CFG_RATE_W - 1;

    always_comb begin
        cfg_o.enable = ctrl_i[CFG_EN_BIT];
        cfg_o.rate   = rate_e'(ctrl_i[RATE_MSB:CFG_RATE_LSB]);
    end

    // Remaining control bits belong to other functions.
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl_i;

endmodule

// File: rtl/tpg_sync_edge.sv
module tpg_sync_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sync_i,
    output logic sync_lvl_o,
    output logic sync_rise_o
);

    logic sync_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_i;
        end
    end

    assign sync_lvl_o  = sync_q;
    assign sync_rise_o = sync_i & ~sync_q;

    // R6: a detected rise cannot repeat on the following cycle
    p_rise_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_rise_o |=> !sync_rise_o);

endmodule

// File: rtl/tpg_rate_timer.sv
module tpg_rate_timer
    import tpg_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned BASE_HZ = 100
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  tpg_cfg_t cfg_i,
    input  logic     sync_rise_i,
    output logic     tick_o,
    output logic     mode_sync_o
);

    localparam int unsigned BASE_PERIOD = CLK_HZ / BASE_HZ;
    localparam int          CNT_W       = $clog2(BASE_PERIOD);

    // Terminal count per code, one entry per rate step.
    logic [CNT_W-1:0] term_tbl [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_term
        if (g < NUM_CODES - 1) begin : g_timed
            assign term_tbl[g] = CNT_W'(period_of(BASE_PERIOD, g) - 1);
        end else begin : g_sync
            assign term_tbl[g] = '0;
        end
    end

    logic [CNT_W-1:0] cnt_q;
    rate_e            act_q;
    logic             running_q;
    rate_e            cur_rate;
    logic             timed;
    logic             wrap;

    always_comb begin
        // First enabled cycle adopts the requested code directly.
        cur_rate = running_q ? act_q : cfg_i.rate;
        timed    = is_timed(cur_rate);
        wrap     = cfg_i.enable && timed && (cnt_q == term_tbl[cur_rate]);
        if (!cfg_i.enable) begin
            tick_o = 1'b0;
        end else if (timed) begin
            tick_o = wrap;
        end else begin
            tick_o = sync_rise_i;
        end
    end

    assign mode_sync_o = cfg_i.enable && !timed;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q     <= '0;
            act_q     <= RATE_100HZ;
            running_q <= 1'b0;
        end else if (!cfg_i.enable) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else begin
            running_q <= 1'b1;
            if (!timed || wrap || !running_q) begin
                act_q <= cfg_i.rate;
            end
            if (!timed || wrap) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the counter never passes the terminal count of the active code
    p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (running_q && is_timed(act_q)) |-> (cnt_q <= term_tbl[act_q]));

    // R5: the active code only moves at a period boundary while running
    p_rate_held_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_i.enable && running_q && is_timed(act_q) && !wrap) |=> $stable(act_q));

    // R1: a disabled timer restarts from zero
    p_disabled_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_i.enable |=> (cnt_q == '0));

endmodule

// File: rtl/tpg_out_stage.sv
module tpg_out_stage
    import tpg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      enable_i,
    input  logic      tick_i,
    input  logic      sync_lvl_i,
    input  insp_sel_e insp_sel_i,
    output logic      pulse_o,
    output logic      insp_o
);

    logic pulse_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_q <= 1'b0;
        end else begin
            // Guard against back-to-back ticks across a mode switch.
            pulse_q <= enable_i & tick_i & ~pulse_q;
        end
    end

    always_comb begin
        unique case (insp_sel_i)
            INSP_SYNC:  insp_o = sync_lvl_i;
            INSP_PULSE: insp_o = pulse_q;
            default:    insp_o = 1'b0;
        endcase
    end

    assign pulse_o = pulse_q;

    // R6: every strobe lasts a single cycle
    p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_q |=> !pulse_q);

    // R1: no strobe follows a cycle with enable low
    p_quiet_when_off_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> !pulse_q);

    // R8: reset leaves the strobe low
    p_reset_low_r8: assert property (@(posedge clk_i)
        $past(rst_i) |-> !pulse_q);

endmodule

// File: rtl/tpg_pulse_gen.sv
module tpg_pulse_gen
    import tpg_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 200_000_000,
    parameter int unsigned BASE_HZ = 100,
    parameter int          CTRL_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              sync_i,
    input  logic [1:0]        insp_sel_i,
    output logic              pulse_o,
    output logic              insp_o
);

    tpg_cfg_t cfg;
    logic     sync_lvl;
    logic     sync_rise;
    logic     tick;
    logic     mode_sync;

    tpg_cfg_decode #(.CTRL_W(CTRL_W)) u_decode (
        .ctrl_i (ctrl_i),
        .cfg_o  (cfg)
    );

    tpg_sync_edge u_sync (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sync_i      (sync_i),
        .sync_lvl_o  (sync_lvl),
        .sync_rise_o (sync_rise)
    );

    tpg_rate_timer #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ)) u_timer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_i       (cfg),
        .sync_rise_i (sync_rise),
        .tick_o      (tick),
        .mode_sync_o (mode_sync)
    );

    tpg_out_stage u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .enable_i   (cfg.enable),
        .tick_i     (tick),
        .sync_lvl_i (sync_lvl),
        .insp_sel_i (insp_sel_e'(insp_sel_i)),
        .pulse_o    (pulse_o),
        .insp_o     (insp_o)
    );

    // R4: in follow mode a SYNC rise is forwarded on the next edge
    p_sync_follow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_sync && sync_rise && !pulse_o) |=> pulse_o);

    // R4: in timer mode the strobe only comes from the counter, never from SYNC
    p_timed_no_sync_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg.enable && !mode_sync && sync_rise && !tick) |=> !pulse_o);

endmodule

// File: tb/tpg_pulse_gen_bench.sv
module tpg_pulse_gen_bench;

    localparam int unsigned CLK_HZ  = 25_600;
    localparam int unsigned BASE_HZ = 100;
    localparam int          BASE_P  = CLK_HZ / BASE_HZ;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl = '0;
    logic        sync = 1'b0;
    logic [1:0]  insp_sel = 2'd1;
    logic        pulse;
    logic        insp;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    int    exp_q[$];
    string cur_req = "R3";
    logic  prev_pulse = 1'b0;
    logic  done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tpg_pulse_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ)) u_tpg_pulse_gen (
        .clk_i      (clk),
        .rst_i      (rst),
        .ctrl_i     (ctrl),
        .sync_i     (sync),
        .insp_sel_i (insp_sel),
        .pulse_o    (pulse),
        .insp_o     (insp)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int per(input int code);
        return BASE_P >> code;
    endfunction

    // Drive a control word at a falling edge; returns the cycle stamp.
    task automatic apply(input logic en, input int code, input logic [10:0] junk, output int n);
        @(negedge clk);
        ctrl = {1'b1 & junk[0], code[2:0], en, junk};
        n = cyc;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // Monitor: pops predicted pulse cycles and compares.
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse) begin
                if (prev_pulse) chk(1'b0, "R6", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected pulse"}, cyc, -1);
                end else begin
                    chk(cyc == exp_q[0], cur_req, cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                if (insp_sel == 2'd1) chk(insp == 1'b1, "R7", insp, 1);
            end
            prev_pulse = pulse;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int m;
        // R8: reset holds outputs low even with a live config
        ctrl = 16'h6800;
        repeat (4) @(negedge clk);
        chk(pulse == 1'b0, "R8", pulse, 0);
        chk(insp == 1'b0, "R8", insp, 0);
        rst = 1'b0;

        // R1/R2: enable clear with all other low bits set
        cur_req = "R1";
        apply(1'b0, 6, 11'h7FF, n);
        wait_until(n + 60);
        drained("R1");

        // R3/R2: every timed code, junk bits alternating
        for (int c = 0; c < 7; c++) begin
            cur_req = "R3";
            apply(1'b1, c, (c % 2 == 1) ? 11'h7FF : 11'h000, n);
            for (int k = 1; k <= 3; k++) exp_q.push_back(n + k * per(c));
            wait_until(n + 3 * per(c) + 1);
            apply(1'b0, c, 11'h0, m);
            repeat (10) @(negedge clk);
            drained("R3");
        end

        // R1: disable mid-interval, then re-enable gives a full interval
        cur_req = "R1";
        apply(1'b1, 5, 11'h0, n);
        exp_q.push_back(n + 8);
        wait_until(n + 11);
        apply(1'b0, 5, 11'h0, m);
        repeat (20) @(negedge clk);
        apply(1'b1, 5, 11'h0, m);
        exp_q.push_back(m + 8);
        exp_q.push_back(m + 16);
        wait_until(m + 17);
        apply(1'b0, 5, 11'h0, m);
        repeat (10) @(negedge clk);
        drained("R1");

        // R5: slow to fast mid-interval
        cur_req = "R5";
        apply(1'b1, 3, 11'h0, n);
        exp_q.push_back(n + 32);
        exp_q.push_back(n + 64);
        wait_until(n + 40);
        apply(1'b1, 6, 11'h0, m);
        exp_q.push_back(n + 68);
        exp_q.push_back(n + 72);
        wait_until(n + 73);
        apply(1'b0, 6, 11'h0, m);
        repeat (10) @(negedge clk);
        drained("R5");

        // R5: fast to slow mid-interval
        apply(1'b1, 6, 11'h0, n);
        exp_q.push_back(n + 4);
        exp_q.push_back(n + 8);
        exp_q.push_back(n + 72);
        wait_until(n + 5);
        apply(1'b1, 2, 11'h0, m);
        wait_until(n + 73);
        apply(1'b0, 2, 11'h0, m);
        repeat (10) @(negedge clk);
        drained("R5");

        // R4: SYNC ignored in timer mode
        cur_req = "R4";
        apply(1'b1, 4, 11'h0, n);
        exp_q.push_back(n + 16);
        wait_until(n + 5);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        wait_until(n + 17);
        apply(1'b0, 4, 11'h0, m);
        repeat (10) @(negedge clk);
        drained("R4");

        // R4/R6/R7: follow mode, long and short SYNC
        insp_sel = 2'd0;
        apply(1'b1, 7, 11'h0, n);
        repeat (10) @(negedge clk);
        sync = 1'b1;
        m = cyc;
        exp_q.push_back(m + 1);
        @(negedge clk);
        chk(insp == 1'b1, "R7", insp, 1);
        repeat (4) @(negedge clk);
        sync = 1'b0;
        @(negedge clk);
        chk(insp == 1'b0, "R7", insp, 0);
        repeat (20) @(negedge clk);
        insp_sel = 2'd2;
        sync = 1'b1;
        m = cyc;
        exp_q.push_back(m + 1);
        @(negedge clk);
        chk(insp == 1'b0, "R7", insp, 0);
        sync = 1'b0;
        insp_sel = 2'd1;
        repeat (300) @(negedge clk);
        drained("R4");

        // R1: SYNC while disabled gives nothing
        cur_req = "R1";
        apply(1'b0, 7, 11'h0, n);
        repeat (5) @(negedge clk);
        sync = 1'b1;
        repeat (3) @(negedge clk);
        sync = 1'b0;
        repeat (20) @(negedge clk);
        drained("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule